// File: doc/BRIEF.md
# Width-selectable double-buffered SPI host

This block is the transmit/receive engine of an SPI host that runs from the peripheral bus clock. A frame is 8, 16 or 32 bits long, picked by two mode inputs. A 32-bit select input overrides a 16-bit select input. Software writes a word into a one-deep transmit holding buffer. The engine moves that word into a shift register and sends it most significant bit first on `sdo`. In the same frame it captures the same number of bits from `sdi` into a second register, which fills from its top bit downward.

Each finished word is placed in a one-deep receive holding buffer, and a one-cycle completion pulse is raised. Because both sides have a holding buffer, software can queue the next word while the current one is still shifting. The next frame then follows the previous one with no idle clock. `sck` is derived from the bus clock through a 13-bit divider. It idles low. Data is sampled on its rising edge and changed on its falling edge. Dropping `enable` stops a frame that is in flight and blocks further writes.

Top module: `spi_width_host`

## Requirements
- R1: The frame length N is 32 when `mode32`=1 (whatever `mode16` holds), 16 when `mode32`=0 and `mode16`=1, and 8 when both are 0. The mode is taken when a word enters the shift register.
- R2: `sdo` carries bit N-1 of the loaded word first, then the lower bits in descending order, one per `sck` period. Bits of `wr_data` above N-1 are never sent.
- R3: The bit sampled on the first rising `sck` edge lands in bit N-1 of `rd_data`, and later bits follow in descending order. Bits N..31 of `rd_data` read as zero.
- R4: `sck` is low whenever no frame is running. With divider value B, each `sck` half-period is B+1 clocks. A frame started from idle finishes so that `xfer_done` is high in the 1+2·N·(B+1)-th cycle after the clock edge that accepted the write.
- R5: A write (`wr_en`=1 while `enable`=1) clears `tx_empty` at the next edge. When the word moves into the shift register, `tx_empty` returns to 1. From idle this happens one edge after the write.
- R6: A write while `enable`=0 has no effect: `tx_empty` stays 1 and no frame starts.
- R7: A word queued during a frame starts at the same edge that ends that frame. The two `xfer_done` pulses are then exactly 2·N·(B+1) cycles apart.
- R8: `rx_full` rises together with `xfer_done`, and `rd_data` then holds the new word. A one-cycle `rd_en` clears `rx_full` at the next edge.
- R9: If a frame ends while `rx_full`=1 and `rd_en`=0, `rx_ovf` becomes 1 and `rd_data` is replaced by the new word. `rx_ovf` stays 1 until `ovf_clr` is pulsed. A new overflow in the same cycle takes priority over the clear.
- R10: `xfer_done` is high for exactly one cycle per completed frame.
- R11: After reset: `tx_empty`=1, `rx_full`=0, `rx_ovf`=0, `xfer_done`=0, `sck`=0, `sdo`=0.
- R12: Dropping `enable` during a frame returns `sck` and `sdo` to 0 at the next edge, and no `xfer_done` follows for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Engine enable; low aborts a frame and blocks writes |
| mode32 | input | 1 | Selects 32-bit frames (dominant) |
| mode16 | input | 1 | Selects 16-bit frames when mode32 is 0 |
| baud_div | input | 13 | Divider B; sck half-period is B+1 clocks |
| wr_en | input | 1 | Write strobe for the transmit holding buffer |
| wr_data | input | 32 | Word to transmit (low N bits used) |
| rd_en | input | 1 | Read strobe; consumes the receive holding buffer |
| rd_data | output | 32 | Receive holding buffer, zero-extended |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| tx_empty | output | 1 | Transmit holding buffer can take a word |
| rx_full | output | 1 | Receive holding buffer holds an unread word |
| rx_ovf | output | 1 | Sticky: a received word overwrote an unread one |
| xfer_done | output | 1 | One-cycle pulse at the end of each frame |
| sck | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bench builds the block with its default parameters: a 32-bit frame limit and a 13-bit divider field. Within that build it drives divider values 0 to 3, so every frame length and every mode-bit combination, including the dominant 32-bit select, completes in a few hundred cycles. This also lets the 1+2·N·(B+1) completion count and the back-to-back spacing be checked exactly, not bounded. Large divider values take the same counter path and only lengthen each half-period, so they are reached only through the period formula.

// File: rtl/spi_wh_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, the frame-length type and mode decoding for
// the width-selectable SPI host. Assumes a widest frame of FRAME_MAX bits.
package spi_wh_pkg;

    localparam int FRAME_MAX = 32;
    localparam int BITS_W    = $clog2(FRAME_MAX + 1);
    localparam int MID_BITS  = FRAME_MAX / 2;
    localparam int LOW_BITS  = FRAME_MAX / 4;

    typedef enum logic [1:0] {
        FLEN_SHORT = 2'd0,
        FLEN_MID   = 2'd1,
        FLEN_WIDE  = 2'd2
    } flen_e;

    // Decode the two mode inputs; the wide select wins over the mid select.
    function automatic flen_e decode_flen(input logic sel_wide, input logic sel_mid);
        if (sel_wide)
            return FLEN_WIDE;
        else if (sel_mid)
            return FLEN_MID;
        return FLEN_SHORT;
    endfunction

    // Number of bits carried by a frame of the given length class.
    function automatic logic [BITS_W-1:0] flen_bits(input flen_e f);
        case (f)
            FLEN_WIDE: return BITS_W'(FRAME_MAX);
            FLEN_MID:  return BITS_W'(MID_BITS);
            default:   return BITS_W'(LOW_BITS);
        endcase
    endfunction

endpackage

// File: rtl/spi_wh_baud.sv
`timescale 1ns/1ps
// Module: half-period tick generator. While run is high it counts bus
// clocks and emits a one-cycle tick every (div+1) clocks; while run is low
// the count is held at zero so the first tick of a frame comes div+1
// clocks after the frame starts. Assumes div is stable during a frame.
module spi_wh_baud #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             half_tick
);

    logic [DIV_W-1:0] cnt_q;

    assign half_tick = run && (cnt_q == div);

    // Advance the clock count, restarting at each tick and while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || half_tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R4
    tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/spi_wh_shifter.sv
`timescale 1ns/1ps
// Module: serial shift engine. On load it left-aligns the word so bit N-1
// appears first on sdo, clears the capture register and raises sck-low
// phase. Each half tick toggles sck: a rising toggle samples sdi into the
// capture register, a falling toggle advances the transmit register or,
// after the N-th bit, ends the frame. Assumes load is only asserted when
// idle or in the frame_end cycle; abort has priority over everything.
module spi_wh_shifter
    import spi_wh_pkg::*;
#(
    parameter int DATA_W = FRAME_MAX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    input  logic [BITS_W-1:0] load_bits,
    input  logic              half_tick,
    input  logic              sdi,
    output logic              sck,
    output logic              sdo,
    output logic              busy,
    output logic              frame_end,
    output logic [DATA_W-1:0] rx_word
);

    logic [DATA_W-1:0] tx_sh_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic [BITS_W-1:0] bits_q;
    logic [BITS_W-1:0] frame_bits_q;
    logic              sck_q;
    logic              busy_q;
    logic              last_bit;

    assign last_bit  = (bits_q == frame_bits_q);
    assign frame_end = busy_q && half_tick && sck_q && last_bit;
    assign sck       = sck_q;
    assign sdo       = busy_q && tx_sh_q[DATA_W-1];
    assign busy      = busy_q;
    assign rx_word   = rx_sh_q;

    // Sequence one frame: load, then alternate sample and shift half periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh_q      <= '0;
            rx_sh_q      <= '0;
            bits_q       <= '0;
            frame_bits_q <= BITS_W'(LOW_BITS);
            sck_q        <= 1'b0;
            busy_q       <= 1'b0;
        end else if (abort) begin
            sck_q  <= 1'b0;
            busy_q <= 1'b0;
        end else if (load) begin
            tx_sh_q      <= load_word << (BITS_W'(DATA_W) - load_bits);
            rx_sh_q      <= '0;
            bits_q       <= '0;
            frame_bits_q <= load_bits;
            sck_q        <= 1'b0;
            busy_q       <= 1'b1;
        end else if (busy_q && half_tick) begin
            if (!sck_q) begin
                sck_q   <= 1'b1;
                rx_sh_q <= {rx_sh_q[DATA_W-2:0], sdi};
                bits_q  <= bits_q + 1'b1;
            end else begin
                sck_q <= 1'b0;
                if (last_bit)
                    busy_q <= 1'b0;
                else
                    tx_sh_q <= tx_sh_q << 1;
            end
        end
    end

    // R4
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sck_q);

    // R1
    bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (bits_q <= frame_bits_q));

    // R12
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy_q && !sck_q && !sdo));

endmodule

// File: rtl/spi_wh_buffers.sv
`timescale 1ns/1ps
// Module: one-deep transmit and receive holding buffers with their flags.
// The transmit side accepts writes only while enabled and reports empty
// once the engine has taken the word. The receive side captures each
// finished word, tracks unread data and records overwrites in a sticky
// flag. Also registers the one-cycle completion pulse.
module spi_wh_buffers #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    input  logic              frame_end,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              rd_en,
    input  logic              ovf_clr,
    output logic [DATA_W-1:0] tx_word,
    output logic              tx_empty,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_ovf,
    output logic              done
);

    logic              wr_ok;
    logic              ovf_set;
    logic [DATA_W-1:0] tx_buf_q;
    logic              tx_empty_q;
    logic [DATA_W-1:0] rx_buf_q;
    logic              rx_full_q;
    logic              rx_ovf_q;
    logic              done_q;

    assign wr_ok    = enable && wr_en;
    assign ovf_set  = frame_end && rx_full_q && !rd_en;
    assign tx_word  = tx_buf_q;
    assign tx_empty = tx_empty_q;
    assign rx_data  = rx_buf_q;
    assign rx_full  = rx_full_q;
    assign rx_ovf   = rx_ovf_q;
    assign done     = done_q;

    // Hold the queued transmit word and its empty flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf_q   <= '0;
            tx_empty_q <= 1'b1;
        end else if (wr_ok) begin
            tx_buf_q   <= wr_data;
            tx_empty_q <= 1'b0;
        end else if (load) begin
            tx_empty_q <= 1'b1;
        end
    end

    // Capture each finished word and track whether it has been read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf_q  <= '0;
            rx_full_q <= 1'b0;
        end else if (frame_end) begin
            rx_buf_q  <= rx_word;
            rx_full_q <= 1'b1;
        end else if (rd_en) begin
            rx_full_q <= 1'b0;
        end
    end

    // Keep the sticky overwrite flag; a new overwrite beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_ovf_q <= 1'b0;
        else if (ovf_set)
            rx_ovf_q <= 1'b1;
        else if (ovf_clr)
            rx_ovf_q <= 1'b0;
    end

    // Register the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else
            done_q <= frame_end;
    end

    // R5
    tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> !tx_empty_q);

    // R6
    ignore_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && tx_empty_q && !load) |=> tx_empty_q);

    // R8
    full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full_q) |-> done_q);

    // R9
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> rx_ovf_q);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/spi_width_host.sv
`timescale 1ns/1ps
// Module: width-selectable SPI host top. Decodes the frame length from the
// mode inputs, decides when the queued word enters the shift engine (from
// idle, or in the cycle a frame ends) and wires the divider, engine and
// holding buffers together. Assumes mode and divider inputs are stable
// while a frame is shifting; SPI mode 0 timing.
module spi_width_host
    import spi_wh_pkg::*;
#(
    parameter int DIV_W = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 mode32,
    input  logic                 mode16,
    input  logic [DIV_W-1:0]     baud_div,
    input  logic                 wr_en,
    input  logic [FRAME_MAX-1:0] wr_data,
    input  logic                 rd_en,
    output logic [FRAME_MAX-1:0] rd_data,
    input  logic                 ovf_clr,
    output logic                 tx_empty,
    output logic                 rx_full,
    output logic                 rx_ovf,
    output logic                 xfer_done,
    output logic                 sck,
    output logic                 sdo,
    input  logic                 sdi
);

    logic                 busy;
    logic                 frame_end;
    logic                 half_tick;
    logic                 load;
    logic [FRAME_MAX-1:0] tx_word;
    logic [FRAME_MAX-1:0] rx_word;
    logic [BITS_W-1:0]    next_bits;

    // Frame length for the word about to be loaded.
    always_comb begin
        next_bits = flen_bits(decode_flen(mode32, mode16));
    end

    // Start a frame when a word waits and the engine is free or just freed.
    always_comb begin
        load = enable && !tx_empty && (!busy || frame_end);
    end

    spi_wh_baud #(
        .DIV_W (DIV_W)
    ) baud_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .div       (baud_div),
        .half_tick (half_tick)
    );

    spi_wh_shifter #(
        .DATA_W (FRAME_MAX)
    ) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (!enable),
        .load      (load),
        .load_word (tx_word),
        .load_bits (next_bits),
        .half_tick (half_tick),
        .sdi       (sdi),
        .sck       (sck),
        .sdo       (sdo),
        .busy      (busy),
        .frame_end (frame_end),
        .rx_word   (rx_word)
    );

    spi_wh_buffers #(
        .DATA_W (FRAME_MAX)
    ) bufs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .load      (load),
        .frame_end (frame_end),
        .rx_word   (rx_word),
        .rd_en     (rd_en),
        .ovf_clr   (ovf_clr),
        .tx_word   (tx_word),
        .tx_empty  (tx_empty),
        .rx_data   (rd_data),
        .rx_full   (rx_full),
        .rx_ovf    (rx_ovf),
        .done      (xfer_done)
    );

    // R7
    chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && enable && !tx_empty) |=> (busy && !sck));

    // R5
    load_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr_en) |=> tx_empty);

endmodule

// File: tb/spi_width_host_tb.sv
`timescale 1ns/1ps
// Bench: vector table of single frames walked by one loop, then directed
// tests for reset, back-to-back, overflow, ignored writes and abort.
module spi_width_host_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        mode32 = 1'b0;
    logic        mode16 = 1'b0;
    logic [12:0] baud_div = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        ovf_clr = 1'b0;
    logic [31:0] rd_data;
    logic        tx_empty, rx_full, rx_ovf, xfer_done, sck, sdo, sdi;

    int tests = 0;
    int fails = 0;

    // Target device model: presents bit (cur_w-1-rise_cnt) of slv_word,
    // captures sdo on each rising sck.
    int          cur_w = 8;
    int          rise_cnt = 0;
    logic [31:0] slv_word = '0;
    logic [31:0] mosi_cap = '0;

    always #5 clk = ~clk;

    assign sdi = slv_word[cur_w - 1 - rise_cnt];

    always @(posedge sck) begin
        mosi_cap <= {mosi_cap[30:0], sdo};
        rise_cnt <= (rise_cnt == cur_w - 1) ? 0 : rise_cnt + 1;
    end

    spi_width_host dut_i (
        .clk (clk), .rst_n (rst_n), .enable (enable),
        .mode32 (mode32), .mode16 (mode16), .baud_div (baud_div),
        .wr_en (wr_en), .wr_data (wr_data), .rd_en (rd_en),
        .rd_data (rd_data), .ovf_clr (ovf_clr), .tx_empty (tx_empty),
        .rx_full (rx_full), .rx_ovf (rx_ovf), .xfer_done (xfer_done),
        .sck (sck), .sdo (sdo), .sdi (sdi)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int width_of(input logic m32, input logic m16);
        return m32 ? 32 : (m16 ? 16 : 8);
    endfunction

    function automatic logic [31:0] low_bits(input logic [31:0] v, input int n);
        return (n == 32) ? v : (v & ((32'd1 << n) - 1));
    endfunction

    // {mode32, mode16, divider, tx word, target word}
    localparam logic [78:0] VEC [6] = '{
        {1'b0, 1'b0, 13'd1, 32'h0000_00A5, 32'h0000_003C},
        {1'b0, 1'b1, 13'd0, 32'h0000_BEEF, 32'h0000_1234},
        {1'b1, 1'b0, 13'd2, 32'hDEAD_BEEF, 32'h1357_9BDF},
        {1'b1, 1'b1, 13'd0, 32'h8000_0001, 32'hC0FF_EE11},
        {1'b0, 1'b0, 13'd0, 32'hFFFF_FF5A, 32'hFFFF_FF81},
        {1'b0, 1'b1, 13'd3, 32'h1234_0001, 32'h0000_8000}
    };

    // Wait at negedges until xfer_done, counting posedges; returns count.
    task automatic wait_done(output int cyc);
        cyc = 0;
        do begin
            @(posedge clk); cyc++;
            @(negedge clk);
        end while (!xfer_done && cyc < 5000);
    endtask

    task automatic write_word(input logic [31:0] w);
        wr_en = 1'b1; wr_data = w;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_read();
        rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Back-to-back pair; optionally read the first word during the second.
    task automatic run_pair(input logic [31:0] t1, input logic [31:0] t2,
                            input logic [31:0] s1, input logic [31:0] s2,
                            input int b, input bit do_read);
        int cyc;
        int gap;
        mode32 = 1'b0; mode16 = 1'b0; baud_div = 13'(b); cur_w = 8;
        slv_word = s1;
        write_word(t1);
        check(tx_empty == 1'b0, "R5 write clears empty", 32'(tx_empty), 32'd0);
        @(posedge clk); @(negedge clk);
        check(tx_empty == 1'b1, "R5 load sets empty", 32'(tx_empty), 32'd1);
        write_word(t2);
        check(tx_empty == 1'b0, "R7 queued word pending", 32'(tx_empty), 32'd0);
        wait_done(cyc);
        check(rd_data == low_bits(s1, 8), "R7 first rx word", rd_data, low_bits(s1, 8));
        check(low_bits(mosi_cap, 8) == low_bits(t1, 8), "R7 first tx word",
              low_bits(mosi_cap, 8), low_bits(t1, 8));
        slv_word = s2;
        rd_en = do_read;
        gap = 0;
        do begin
            @(posedge clk); gap++;
            @(negedge clk);
            rd_en = 1'b0;
            if (gap == 1) begin
                check(tx_empty == 1'b1, "R7 chained load empties buffer", 32'(tx_empty), 32'd1);
                if (do_read)
                    check(rx_full == 1'b0, "R8 read clears full", 32'(rx_full), 32'd0);
            end
        end while (!xfer_done && gap < 5000);
        check(gap == 16 * (b + 1), "R7 done spacing", 32'(gap), 32'(16 * (b + 1)));
        check(rd_data == low_bits(s2, 8), "R9 latest rx word", rd_data, low_bits(s2, 8));
        check(low_bits(mosi_cap, 8) == low_bits(t2, 8), "R7 second tx word",
              low_bits(mosi_cap, 8), low_bits(t2, 8));
        check(rx_ovf == !do_read, "R9 overflow flag", 32'(rx_ovf), 32'(!do_read));
    endtask

    initial begin
        #1_500_000;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
        $finish;
    end

    initial begin
        int cyc;
        int n;
        int b;
        int dones;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        check(tx_empty == 1'b1 && rx_full == 1'b0 && rx_ovf == 1'b0,
              "R11 flags after reset", {29'd0, tx_empty, rx_full, rx_ovf}, 32'h4);
        check(xfer_done == 1'b0 && sck == 1'b0 && sdo == 1'b0,
              "R11 lines after reset", {29'd0, xfer_done, sck, sdo}, 32'h0);
        rst_n = 1'b1;
        enable = 1'b1;
        @(negedge clk);

        // Vector table: single frames from idle.
        for (int i = 0; i < 6; i++) begin
            mode32   = VEC[i][78];
            mode16   = VEC[i][77];
            baud_div = VEC[i][76:64];
            n        = width_of(VEC[i][78], VEC[i][77]);
            b        = int'(VEC[i][76:64]);
            cur_w    = n;
            slv_word = VEC[i][31:0];
            write_word(VEC[i][63:32]);
            check(tx_empty == 1'b0, "R5 empty cleared by write", 32'(tx_empty), 32'd0);
            wait_done(cyc);
            // R4, R1: completion time follows from N and B
            check(cyc == 1 + 2 * n * (b + 1), "R4 R1 frame length in cycles",
                  32'(cyc), 32'(1 + 2 * n * (b + 1)));
            check(low_bits(mosi_cap, n) == low_bits(VEC[i][63:32], n), "R2 sdo word",
                  low_bits(mosi_cap, n), low_bits(VEC[i][63:32], n));
            check(rd_data == low_bits(VEC[i][31:0], n), "R3 rx word zero-extended",
                  rd_data, low_bits(VEC[i][31:0], n));
            check(rx_full == 1'b1 && tx_empty == 1'b1, "R8 full with done",
                  {30'd0, rx_full, tx_empty}, 32'h3);
            @(negedge clk);
            check(xfer_done == 1'b0 && sck == 1'b0, "R10 done one cycle, R4 sck idle",
                  {30'd0, xfer_done, sck}, 32'h0);
            pulse_read();
            check(rx_full == 1'b0 && rx_ovf == 1'b0, "R8 read clears full",
                  {30'd0, rx_full, rx_ovf}, 32'h0);
        end

        // R7 back-to-back with read in between: no overflow.
        run_pair(32'h0000_00A1, 32'h0000_003C, 32'h0000_0096, 32'h0000_0069, 1, 1'b1);
        pulse_read();

        // R9 back-to-back without read: overflow, then sticky, then cleared.
        run_pair(32'h0000_00F0, 32'h0000_000F, 32'h0000_0011, 32'h0000_00EE, 0, 1'b0);
        repeat (5) @(negedge clk);
        check(rx_ovf == 1'b1, "R9 overflow sticky", 32'(rx_ovf), 32'd1);
        ovf_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        ovf_clr = 1'b0;
        check(rx_ovf == 1'b0, "R9 clear by ovf_clr", 32'(rx_ovf), 32'd0);
        check(rx_full == 1'b1, "R8 full kept without read", 32'(rx_full), 32'd1);
        pulse_read();
        check(rx_full == 1'b0, "R8 read clears full", 32'(rx_full), 32'd0);

        // R6 writes while disabled are ignored.
        enable = 1'b0;
        @(negedge clk);
        write_word(32'h0000_00C3);
        check(tx_empty == 1'b1, "R6 disabled write ignored", 32'(tx_empty), 32'd1);
        dones = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (sck || xfer_done) dones++;
        end
        check(dones == 0, "R6 no frame while disabled", 32'(dones), 32'd0);

        // R12 abort a running 32-bit frame.
        enable = 1'b1; mode32 = 1'b1; baud_div = 13'd3; cur_w = 32;
        slv_word = 32'hA5A5_A5A5;
        @(negedge clk);
        write_word(32'hFFFF_FFFF);
        repeat (20) @(negedge clk);
        enable = 1'b0;
        @(posedge clk); @(negedge clk);
        check(sck == 1'b0 && sdo == 1'b0, "R12 lines low after abort",
              {30'd0, sck, sdo}, 32'h0);
        dones = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (xfer_done || sck) dones++;
        end
        check(dones == 0, "R12 no completion after abort", 32'(dones), 32'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule